// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block behaves as the target side of a byte-addressed serial EEPROM on a two-wire bus. It keeps 4096 bytes in an internal array. A fast system clock samples the bus clock and data lines, so the block needs no clock of its own from the bus. It recognises framing conditions and answers only when the select byte carries its family code and the value of its three strap inputs. It takes a 12-bit word address and then serves page writes, current-address reads, random reads and sequential reads.

The data line is open-drain. The block never drives it high. Its single output is an enable that, when set, pulls the shared line low. A write-protect input leaves the whole array read-only while still letting the bus protocol complete. Write-cycle delay, analog timing and power modes are not modelled.

Top module: `tw_eeprom_slave`

## Requirements
- R1: A falling data line while the clock line is high is a start. From any state, a start discards any partially received byte and waits for a select byte.
- R2: A rising data line while the clock line is high is a stop. After a stop, and after reset, the block releases the data line and waits for a start.
- R3: The select byte is 1010 in bits 7..4, followed by the strap inputs in bits 3..1 and the direction in bit 0 (1 means read). A select byte that does not match gets no acknowledge. The block then ignores the bus, including any later bytes, until the next start.
- R4: The block acknowledges each matched select byte, each address byte and each write data byte. It does this by pulling the data line low for the whole of the ninth clock.
- R5: Bytes travel most significant bit first. Bits are sampled on the clock's rising edge. The block changes its data-line output only after a clock falling edge, a start or a stop.
- R6: A write first sends a high address byte and then a low address byte. Only bits 3..0 of the high byte are used, which gives a 12-bit word address. Bits 7..4 of the high byte are ignored.
- R7: During a write, each data byte goes to the current address. The low 5 address bits then advance and wrap within the 32-byte page, while the upper 7 bits stay fixed.
- R8: During a read, each byte the master acknowledges advances the address across the whole array. The address wraps from 4095 to 0, and the next byte is sent starting with the following falling edge.
- R9: When the master does not acknowledge a read byte, the read ends. The block leaves the data line released until the next start.
- R10: While write-protect is high, write data bytes are still acknowledged, but the array does not change. While it is low, writes take effect.
- R11: A read issued without a preceding address write starts at the address that follows the last byte accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level, as seen on the wired line |
| strap_i | input | 3 | Device strap inputs compared with select byte bits 3..1 |
| wp_i | input | 1 | Write protect: high blocks all array writes |
| sda_oe_o | output | 1 | When high, pulls the data line low |

## Verification
The bench goes after the ways an address counter can go wrong. A page write that crosses byte 31 must land at byte 0 of the same page, and a design that carried into the page bits would corrupt the next page. A sequential read starting at 4095 must continue at 0, and one that crosses a page boundary must not wrap. A current-address read must continue after the last byte read, and one that reused the old address or was off by one would return the wrong byte. Other checks cover a start that arrives mid-byte, which a design without reframing would misalign. They also cover a wrong strap value or family code, which a loose compare would acknowledge, ignored upper address bits, and a protected write that must still be acknowledged yet leave the old data in place.

// File: rtl/tw_ee_pkg.sv
package tw_ee_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam logic [3:0]  FAMILY_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_RD
  } tw_state_e;

endpackage

// File: rtl/tw_bus_sync.sv
module tw_bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [1:0] raw;
  logic [1:0] lvl;
  logic [1:0] dly;

  assign raw = {scl_i, sda_i};

  // index 1 = clock line, index 0 = data line
  genvar g;
  for (g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic              dly_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '1;
        dly_q   <= 1'b1;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], raw[g]};
        dly_q   <= chain_q[LAST];
      end
    end

    assign lvl[g] = chain_q[LAST];
    assign dly[g] = dly_q;
  end

  assign sda_lvl_o  = lvl[0];
  assign scl_rise_o = lvl[1] & ~dly[1];
  assign scl_fall_o = ~lvl[1] & dly[1];
  assign start_o    = lvl[1] & dly[1] & dly[0] & ~lvl[0];
  assign stop_o     = lvl[1] & dly[1] & ~dly[0] & lvl[0];

  p_edges_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({scl_rise_o, scl_fall_o, start_o, stop_o}) <= 1);

endmodule

// File: rtl/tw_mem_array.sv
module tw_mem_array #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];

  // write strobe comes from the controller; protection is checked here
  p_wp_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wp_i |-> !we_i);

endmodule

// File: rtl/tw_slave_ctrl.sv
module tw_slave_ctrl
  import tw_ee_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        strap_i,
  input  logic              wp_i,
  input  logic              sda_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              sda_oe_o
);

  localparam int unsigned HI_W = ADDR_W - BYTE_W;

  tw_state_e         state_q, state_d;
  logic [3:0]        bitcnt_q, bitcnt_d;
  logic              ackph_q, ackph_d;
  logic [BYTE_W-1:0] shreg_q, shreg_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              oe_q, oe_d;
  logic              mem_we;
  logic              byte_full;
  logic              sel_match;

  assign byte_full = (bitcnt_q == 4'd8);
  assign sel_match = (shreg_q[7:1] == {FAMILY_CODE, strap_i});

  always_comb begin
    state_d  = state_q;
    bitcnt_d = bitcnt_q;
    ackph_d  = ackph_q;
    shreg_d  = shreg_q;
    tx_d     = tx_q;
    addr_d   = addr_q;
    oe_d     = oe_q;
    mem_we   = 1'b0;

    if (start_i) begin
      state_d  = ST_SEL;
      bitcnt_d = '0;
      ackph_d  = 1'b0;
      oe_d     = 1'b0;
    end else if (stop_i) begin
      state_d  = ST_IDLE;
      bitcnt_d = '0;
      ackph_d  = 1'b0;
      oe_d     = 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          oe_d = 1'b0;
        end

        ST_RD: begin
          if (scl_rise_i) begin
            if (ackph_q && byte_full) begin
              // master acknowledge slot
              if (!sda_lvl_i) begin
                tx_d   = rdata_i;
                addr_d = addr_q + 1'b1;
              end else begin
                state_d = ST_IDLE;
                ackph_d = 1'b0;
              end
            end else if (!ackph_q && !byte_full) begin
              bitcnt_d = bitcnt_q + 4'd1;
            end
          end else if (scl_fall_i) begin
            if (ackph_q) begin
              ackph_d  = 1'b0;
              bitcnt_d = '0;
              oe_d     = ~tx_q[BYTE_W-1];
            end else if (byte_full) begin
              ackph_d = 1'b1;
              oe_d    = 1'b0;
            end else begin
              oe_d = ~tx_q[3'd7 - bitcnt_q[2:0]];
            end
          end
        end

        default: begin
          if (scl_rise_i && !ackph_q && !byte_full) begin
            shreg_d  = {shreg_q[BYTE_W-2:0], sda_lvl_i};
            bitcnt_d = bitcnt_q + 4'd1;
          end else if (scl_fall_i) begin
            if (ackph_q) begin
              ackph_d  = 1'b0;
              bitcnt_d = '0;
              oe_d     = 1'b0;
            end else if (byte_full) begin
              ackph_d = 1'b1;
              oe_d    = 1'b1;
              case (state_q)
                ST_SEL: begin
                  if (!sel_match) begin
                    state_d = ST_IDLE;
                    ackph_d = 1'b0;
                    oe_d    = 1'b0;
                  end else if (shreg_q[0]) begin
                    state_d  = ST_RD;
                    bitcnt_d = '0;
                    tx_d     = rdata_i;
                    addr_d   = addr_q + 1'b1;
                  end else begin
                    state_d = ST_AHI;
                  end
                end
                ST_AHI: begin
                  addr_d  = {shreg_q[HI_W-1:0], addr_q[BYTE_W-1:0]};
                  state_d = ST_ALO;
                end
                ST_ALO: begin
                  addr_d  = {addr_q[ADDR_W-1:BYTE_W], shreg_q};
                  state_d = ST_WR;
                end
                default: begin
                  mem_we = ~wp_i;
                  addr_d = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + 1'b1};
                end
              endcase
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      ackph_q  <= 1'b0;
      shreg_q  <= '0;
      tx_q     <= '0;
      addr_q   <= '0;
      oe_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      ackph_q  <= ackph_d;
      shreg_q  <= shreg_d;
      tx_q     <= tx_d;
      addr_q   <= addr_d;
      oe_q     <= oe_d;
    end
  end

  assign mem_we_o = mem_we;
  assign addr_o   = addr_q;
  assign wdata_o  = shreg_q;
  assign sda_oe_o = oe_q;

  p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !oe_q);

  p_oe_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> $past(scl_fall_i || start_i || stop_i));

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !oe_q);

  p_bitcnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt_q <= 4'd8);

  p_page_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> addr_q[ADDR_W-1:PAGE_W] == $past(addr_q[ADDR_W-1:PAGE_W]));

  p_nack_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD && ackph_q && byte_full && scl_rise_i && sda_lvl_i) |=> !oe_q);

endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave
  import tw_ee_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned PAGE_W      = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);

  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic              sda_lvl;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [BYTE_W-1:0] mem_wdata;
  logic [BYTE_W-1:0] mem_rdata;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  tw_bus_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_lvl_o  (sda_lvl),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  tw_slave_ctrl #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .strap_i    (strap_i),
    .wp_i       (wp_i),
    .sda_lvl_i  (sda_lvl),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .rdata_i    (mem_rdata),
    .mem_we_o   (mem_we),
    .addr_o     (mem_addr),
    .wdata_o    (mem_wdata),
    .sda_oe_o   (sda_oe_o)
  );

  tw_mem_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (BYTE_W)
  ) u_mem (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wp_i    (wp_i),
    .we_i    (mem_we),
    .addr_i  (mem_addr),
    .wdata_i (mem_wdata),
    .rdata_o (mem_rdata)
  );

endmodule

// File: tb/tw_eeprom_slave_tb.sv
module tw_eeprom_slave_tb;

  localparam int Q = 5;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] SEL_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] SEL_R = {4'b1010, STRAP, 1'b1};
  localparam int NVEC = 14;
  // {op(1=write,2=read), addr high byte, addr low byte, data}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'h01, 8'h00, 8'h10, 8'h3C},
    {8'h01, 8'hF1, 8'h23, 8'h80},
    {8'h01, 8'h0A, 8'hBC, 8'h01},
    {8'h01, 8'h0F, 8'hFF, 8'h5A},
    {8'h01, 8'h00, 8'h00, 8'hA5},
    {8'h01, 8'h00, 8'h01, 8'h77},
    {8'h01, 8'h00, 8'h1F, 8'hC3},
    {8'h01, 8'h00, 8'h20, 8'h96},
    {8'h01, 8'h00, 8'h40, 8'h11},
    {8'h02, 8'h00, 8'h10, 8'h3C},
    {8'h02, 8'h01, 8'h23, 8'h80},
    {8'h02, 8'hE1, 8'h23, 8'h80},
    {8'h02, 8'h0A, 8'hBC, 8'h01},
    {8'h02, 8'h0F, 8'hFF, 8'h5A}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic scl;
  logic sda_m;
  logic wp;
  logic sda_oe;
  logic sda_line;
  int   tests = 0;
  int   fails = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  tw_eeprom_slave u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl),
    .sda_i    (sda_line),
    .strap_i  (STRAP),
    .wp_i     (wp),
    .sda_oe_o (sda_oe)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait();
    scl = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; qwait();
    scl = 1'b1; qwait(); qwait();
    scl = 1'b0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; qwait();
    scl = 1'b1; qwait();
    ack = ~sda_line;
    qwait();
    scl = 1'b0; qwait();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qwait();
      scl = 1'b1; qwait();
      b[i] = sda_line;
      qwait();
      scl = 1'b0;
    end
    sda_m = ~mack; qwait();
    scl = 1'b1; qwait(); qwait();
    scl = 1'b0; qwait();
    sda_m = 1'b1;
  endtask

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, output logic ok);
    logic a0, a1, a2;
    bus_start();
    send_byte(SEL_W, a0);
    send_byte(hi, a1);
    send_byte(lo, a2);
    ok = a0 & a1 & a2;
  endtask

  task automatic write_one(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] d, output logic ok);
    logic a, a3;
    set_addr(hi, lo, a);
    send_byte(d, a3);
    bus_stop();
    ok = a & a3;
  endtask

  task automatic read_one(input logic [7:0] hi, input logic [7:0] lo, output logic [7:0] d, output logic ok);
    logic a, a4;
    set_addr(hi, lo, a);
    bus_start();
    send_byte(SEL_R, a4);
    recv_byte(1'b0, d);
    bus_stop();
    ok = a & a4;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic       ok, a0, a1, a2, a3;
    logic [7:0] d, d2;
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; wp = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R2: released after reset
    check(sda_oe == 1'b0, "R2 reset release", 32'(sda_oe), 0);

    // table walk: R4 acks on writes, R6 addressing with ignored high bits, R5 bit order
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][31:24] == 8'h01) begin
        write_one(VEC[v][23:16], VEC[v][15:8], VEC[v][7:0], ok);
        check(ok, "R4 write ack", 32'(ok), 1);
      end else begin
        read_one(VEC[v][23:16], VEC[v][15:8], d, ok);
        check(ok && d == VEC[v][7:0], "R6 R5 random read", {23'd0, ok, d}, {23'd0, 1'b1, VEC[v][7:0]});
      end
    end
    check(sda_oe == 1'b0, "R2 stop release", 32'(sda_oe), 0);

    // R7: page write from 0x03E wraps to 0x020
    set_addr(8'h00, 8'h3E, ok);
    send_byte(8'hE0, a0); send_byte(8'hE1, a1);
    send_byte(8'hE2, a2); send_byte(8'hE3, a3);
    bus_stop();
    check(ok & a0 & a1 & a2 & a3, "R7 page write acks", 32'({ok, a0, a1, a2, a3}), 32'h1F);
    read_one(8'h00, 8'h20, d, ok);
    check(d == 8'hE2, "R7 wrap to page start", 32'(d), 32'hE2);
    read_one(8'h00, 8'h21, d, ok);
    check(d == 8'hE3, "R7 wrap second byte", 32'(d), 32'hE3);
    read_one(8'h00, 8'h3F, d, ok);
    check(d == 8'hE1, "R7 page end", 32'(d), 32'hE1);
    read_one(8'h00, 8'h40, d, ok);
    check(d == 8'h11, "R7 next page untouched", 32'(d), 32'h11);

    // R8: sequential read across a page boundary
    set_addr(8'h00, 8'h1F, ok);
    bus_start(); send_byte(SEL_R, a0);
    recv_byte(1'b1, d); recv_byte(1'b0, d2);
    bus_stop();
    check(d == 8'hC3 && d2 == 8'hE2, "R8 cross page read", {16'd0, d, d2}, 32'hC3E2);

    // R8: wrap from 4095 to 0; R9: release after nack
    set_addr(8'h0F, 8'hFF, ok);
    bus_start(); send_byte(SEL_R, a0);
    recv_byte(1'b1, d); recv_byte(1'b0, d2);
    repeat (4) @(negedge clk);
    check(sda_oe == 1'b0, "R9 release after nack", 32'(sda_oe), 0);
    bus_stop();
    check(d == 8'h5A && d2 == 8'hA5, "R8 array wrap", {16'd0, d, d2}, 32'h5AA5);

    // R11: current-address read continues at 0x001
    bus_start(); send_byte(SEL_R, a0);
    recv_byte(1'b0, d); bus_stop();
    check(a0 && d == 8'h77, "R11 current address read", {23'd0, a0, d}, 32'h177);

    // R10: protected write acknowledged but not stored
    wp = 1'b1;
    write_one(8'h00, 8'h10, 8'hFF, ok);
    wp = 1'b0;
    check(ok, "R10 protected write ack", 32'(ok), 1);
    read_one(8'h00, 8'h10, d, ok);
    check(d == 8'h3C, "R10 array unchanged", 32'(d), 32'h3C);

    // R3: wrong strap then trailing bytes ignored
    bus_start();
    send_byte({4'b1010, 3'b011, 1'b0}, a0);
    send_byte(8'h00, a1); send_byte(8'h10, a2); send_byte(8'h00, a3);
    bus_stop();
    check(!(a0 | a1 | a2 | a3), "R3 strap mismatch ignored", 32'({a0, a1, a2, a3}), 0);
    bus_start(); send_byte(8'hBA, a0); bus_stop();
    check(!a0, "R3 family code mismatch", 32'(a0), 0);
    read_one(8'h00, 8'h10, d, ok);
    check(d == 8'h3C, "R3 array untouched", 32'(d), 32'h3C);

    // R1: start in the middle of a byte reframes
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    read_one(8'h00, 8'h40, d, ok);
    check(ok && d == 8'h11, "R1 restart mid byte", {23'd0, ok, d}, 32'h111);

    done = 1'b1;
    finish_run();
  end

endmodule